// File: doc/BRIEF.md
# Multi-FIFO Synchronous Slave Port

This block is a slave port on the chip boundary. An outside bus master uses it to move packet data into and out of four internal FIFOs over one shared bidirectional data bus. Every transfer is timed by the interface clock. A two-bit select input chooses the FIFO that the read, write, output-enable and packet-end strobes act on. The block reports registered full and empty flags for the selected FIFO.

Written words are held back as an open packet. They become readable only once the packet is committed. A packet is committed in one of two ways: automatically, when its byte count reaches the programmed length, or on a packet-end strobe, which closes a short packet early. The bus is 16 bits wide, or 8 bits wide when the narrow setting is chosen. A polarity vector sets each strobe as active high or active low.

Top module: `sfifo_slave_port`

## Requirements
- R1: After the synchronous active-high reset, all FIFOs are empty, the flags read empty=1 and full=0, and the block leaves the data bus undriven.
- R2: The two-bit select input picks the FIFO that each strobe acts on. Data written to one FIFO is never returned by another.
- R3: Polarity bit 0 belongs to the read strobe, bit 1 to write, bit 2 to output enable and bit 3 to packet end. A bit value of 1 makes its strobe active high; a value of 0 makes it active low.
- R4: The block drives bus bits [7:0] only while output enable is active. It drives bits [15:8] only while output enable is active and the wide setting (cfg_wide=1) is selected.
- R5: Output enable without the read strobe shows the word at the read pointer, and the pointer does not move. A read strobe that is active at a rising edge, with data available, advances the pointer, and the next word appears on the bus right after that edge.
- R6: Words that have been written cannot be read until their packet is committed. A write commits the packet when the packet's byte count reaches cfg_pkt_len. Each write adds 2 bytes in wide mode and 1 byte in narrow mode.
- R7: An active packet-end strobe commits the open packet as a short packet. It is ignored when the write strobe is active at the same edge, and when the open packet holds no words.
- R8: A FIFO is full when it holds DEPTH words, or when MAX_PKTS committed packets are still unread. Writes to a full FIFO are dropped.
- R9: A read strobe to a FIFO with no committed data is ignored.
- R10: Each flag is a register. An access at one edge shows up on the flags at the following edge. After the select input changes, the flags describe the new FIFO one edge later.
- R11: In narrow mode only bus bits [7:0] are stored. In wide mode all 16 bits are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus; held static while traffic flows |
| cfg_pol | input | 4 | Strobe polarities (bit 0 read, 1 write, 2 output enable, 3 packet end) |
| cfg_pkt_len | input | LEN_W | Auto-commit packet length in bytes |
| fifo_addr | input | 2 | FIFO select |
| rd_strb | input | 1 | Read strobe |
| wr_strb | input | 1 | Write strobe |
| oe_strb | input | 1 | Output enable |
| end_strb | input | 1 | Packet-end strobe |
| data_bus | inout | BUS_W | Shared data bus |
| flag_full | output | 1 | Selected FIFO is full |
| flag_empty | output | 1 | Selected FIFO has no committed data |

## Verification
Count errors inside the block show up at the ports in three ways:
- A wrong word count or a wrong packet count shows up at the next flag update, one edge after the access that caused it.
- A pointer that is off by one shows up on the bus in the same cycle that output enable is asserted.
- An open packet that is committed too early or too late flips the empty flag one edge sooner or later than the byte count predicts.

Commits that are lost, and writes that leak into a full FIFO, surface when the FIFO is drained. The word sequence read back is then shorter or longer than the sequence written.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  // strobe is active when the pin level equals its polarity bit
  function automatic logic pin_active(input logic pin, input logic pol);
    return ~(pin ^ pol);
  endfunction

  // bytes carried by one bus beat
  function automatic int unsigned beat_bytes(input logic wide);
    return wide ? 32'd2 : 32'd1;
  endfunction

  // auto-commit test on the byte count after a beat
  function automatic logic length_met(input int unsigned filled, input int unsigned target);
    return filled >= target;
  endfunction

endpackage

// File: rtl/sfifo_strobe_pol.sv
module sfifo_strobe_pol
  import sfifo_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] pins,
  input  logic [N-1:0] pol,
  output logic [N-1:0] act
);

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign act[i] = pin_active(pins[i], pol[i]);
  end

endmodule

// File: rtl/sfifo_bank.sv
module sfifo_bank
  import sfifo_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int DEPTH    = 256,
  parameter int MAX_PKTS = 4,
  parameter int LEN_W    = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic              end_req,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              full,
  output logic              empty,
  output logic              wr_fire,
  output logic              rd_fire,
  output logic              end_fire,
  output logic              commit
);

  localparam int PW  = $clog2(DEPTH);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int PKW = $clog2(MAX_PKTS + 1);
  localparam int BW  = LEN_W + 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  last_q;

  logic [PW-1:0]  wr_ptr, rd_ptr;
  logic [CW-1:0]  used_q, avail_q, part_words;
  logic [BW-1:0]  part_bytes;
  logic [PKW-1:0] pkts_q;

  logic [BW-1:0]  next_bytes;
  logic [CW-1:0]  commit_words;
  logic           auto_hit;
  logic           rd_last;

  assign full     = (used_q == CW'(DEPTH)) || (pkts_q == PKW'(MAX_PKTS));
  assign empty    = (avail_q == '0);
  assign wr_fire  = wr_req && !full;
  assign rd_fire  = rd_req && !empty;
  assign rdata    = mem[rd_ptr];
  assign rd_last  = last_q[rd_ptr];

  assign next_bytes   = part_bytes + BW'(beat_bytes(wide));
  assign auto_hit     = wr_fire && length_met(32'(next_bytes), 32'(pkt_len));
  assign end_fire     = end_req && !wr_req && (part_words != '0);
  assign commit       = auto_hit || end_fire;
  assign commit_words = auto_hit ? part_words + CW'(1) : part_words;

  // storage and packet boundary marks; contents need no reset
  always_ff @(posedge clk) begin
    if (wr_fire) begin
      mem[wr_ptr]    <= wdata;
      last_q[wr_ptr] <= auto_hit;
    end else if (end_fire) begin
      last_q[wr_ptr - PW'(1)] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr     <= '0;
      rd_ptr     <= '0;
      used_q     <= '0;
      avail_q    <= '0;
      part_words <= '0;
      part_bytes <= '0;
      pkts_q     <= '0;
    end else begin
      if (wr_fire) wr_ptr <= wr_ptr + PW'(1);
      if (rd_fire) rd_ptr <= rd_ptr + PW'(1);
      used_q  <= used_q + CW'(wr_fire) - CW'(rd_fire);
      avail_q <= avail_q + (commit ? commit_words : CW'(0)) - CW'(rd_fire);
      pkts_q  <= pkts_q + PKW'(commit) - PKW'(rd_fire && rd_last);
      if (commit) begin
        part_words <= '0;
        part_bytes <= '0;
      end else if (wr_fire) begin
        part_words <= part_words + CW'(1);
        part_bytes <= next_bytes;
      end
    end
  end

endmodule

// File: rtl/sfifo_slave_port.sv
module sfifo_slave_port
  import sfifo_pkg::*;
#(
  parameter int BUS_W    = 16,
  parameter int NUM_FIFO = 4,
  parameter int DEPTH    = 256,
  parameter int MAX_PKTS = 4,
  parameter int LEN_W    = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wide,
  input  logic [3:0]       cfg_pol,
  input  logic [LEN_W-1:0] cfg_pkt_len,
  input  logic [1:0]       fifo_addr,
  input  logic             rd_strb,
  input  logic             wr_strb,
  input  logic             oe_strb,
  input  logic             end_strb,
  inout  wire  [BUS_W-1:0] data_bus,
  output logic             flag_full,
  output logic             flag_empty
);

  localparam int HALF = BUS_W / 2;

  logic [3:0] strb_act;
  logic       rd_act, wr_act, oe_act, end_act;

  sfifo_strobe_pol #(.N(4)) u_pol (
    .pins ({end_strb, oe_strb, wr_strb, rd_strb}),
    .pol  (cfg_pol),
    .act  (strb_act)
  );

  assign rd_act  = strb_act[0];
  assign wr_act  = strb_act[1];
  assign oe_act  = strb_act[2];
  assign end_act = strb_act[3];

  logic [BUS_W-1:0]    bus_wdata;
  logic [BUS_W-1:0]    bank_rdata [NUM_FIFO];
  logic [BUS_W-1:0]    sel_rdata;
  logic [NUM_FIFO-1:0] bank_full, bank_empty;
  logic [NUM_FIFO-1:0] wr_fire, rd_fire, end_fire, commit;

  assign bus_wdata = cfg_wide ? data_bus : {{(BUS_W-HALF){1'b0}}, data_bus[HALF-1:0]};

  for (genvar i = 0; i < NUM_FIFO; i++) begin : g_bank
    logic hit;
    assign hit = (fifo_addr == 2'(i));
    sfifo_bank #(
      .WORD_W(BUS_W), .DEPTH(DEPTH), .MAX_PKTS(MAX_PKTS), .LEN_W(LEN_W)
    ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .wide     (cfg_wide),
      .pkt_len  (cfg_pkt_len),
      .wr_req   (wr_act && hit),
      .rd_req   (rd_act && hit),
      .end_req  (end_act && hit),
      .wdata    (bus_wdata),
      .rdata    (bank_rdata[i]),
      .full     (bank_full[i]),
      .empty    (bank_empty[i]),
      .wr_fire  (wr_fire[i]),
      .rd_fire  (rd_fire[i]),
      .end_fire (end_fire[i]),
      .commit   (commit[i])
    );
  end

  assign sel_rdata = bank_rdata[fifo_addr];

  // bus drive: low half with output enable, high half only in wide mode
  assign data_bus[HALF-1:0]     = oe_act ? sel_rdata[HALF-1:0] : {HALF{1'bz}};
  assign data_bus[BUS_W-1:HALF] = (oe_act && cfg_wide) ? sel_rdata[BUS_W-1:HALF]
                                                       : {(BUS_W-HALF){1'bz}};

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_empty <= 1'b1;
      flag_full  <= 1'b0;
    end else begin
      flag_empty <= bank_empty[fifo_addr];
      flag_full  <= bank_full[fifo_addr];
    end
  end

endmodule

module sfifo_slave_port_chk #(
  parameter int NUM_FIFO = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          fifo_addr,
  input logic                rd_act,
  input logic                wr_act,
  input logic                end_act,
  input logic [NUM_FIFO-1:0] wr_fire,
  input logic [NUM_FIFO-1:0] rd_fire,
  input logic [NUM_FIFO-1:0] end_fire,
  input logic [NUM_FIFO-1:0] commit
);

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst) $onehot0(wr_fire)); // R2
  AST_ONE_READER: assert property (@(posedge clk) disable iff (rst) $onehot0(rd_fire)); // R2

  for (genvar i = 0; i < NUM_FIFO; i++) begin : g_chk
    AST_WR_ON_SELECT: assert property (@(posedge clk) disable iff (rst)
      wr_fire[i] |-> (wr_act && fifo_addr == 2'(i))); // R2
    AST_RD_ON_SELECT: assert property (@(posedge clk) disable iff (rst)
      rd_fire[i] |-> (rd_act && fifo_addr == 2'(i))); // R5
    AST_COMMIT_CAUSE: assert property (@(posedge clk) disable iff (rst)
      commit[i] |-> (wr_fire[i] || end_fire[i])); // R6
    AST_END_NOT_WITH_WRITE: assert property (@(posedge clk) disable iff (rst)
      end_fire[i] |-> (end_act && !wr_act && fifo_addr == 2'(i))); // R7
  end

endmodule

bind sfifo_slave_port sfifo_slave_port_chk #(.NUM_FIFO(NUM_FIFO)) u_chk (
  .clk(clk), .rst(rst), .fifo_addr(fifo_addr),
  .rd_act(rd_act), .wr_act(wr_act), .end_act(end_act),
  .wr_fire(wr_fire), .rd_fire(rd_fire), .end_fire(end_fire), .commit(commit)
);

// File: tb/sfifo_slave_port_bench.sv
module sfifo_slave_port_bench;

  localparam int LW = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          wide = 1'b1;
  logic [3:0]    pol = 4'hF;
  logic [LW-1:0] plen = 8'd4;
  logic [1:0]    addr = 2'd0;
  logic          rd_s = 1'b0, wr_s = 1'b0, oe_s = 1'b0, end_s = 1'b0;
  logic [15:0]   m_drv = 16'h0;
  logic          m_lo = 1'b0, m_hi = 1'b0;
  wire  [15:0]   fd;
  logic          ffull, fempty;

  assign fd[7:0]  = m_lo ? m_drv[7:0]  : 8'hzz;
  assign fd[15:8] = m_hi ? m_drv[15:8] : 8'hzz;

  sfifo_slave_port #(
    .BUS_W(16), .NUM_FIFO(4), .DEPTH(8), .MAX_PKTS(4), .LEN_W(LW)
  ) u_sfifo_slave_port (
    .clk(clk), .rst(rst), .cfg_wide(wide), .cfg_pol(pol), .cfg_pkt_len(plen),
    .fifo_addr(addr), .rd_strb(rd_s), .wr_strb(wr_s), .oe_strb(oe_s),
    .end_strb(end_s), .data_bus(fd), .flag_full(ffull), .flag_empty(fempty)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // pin level = active ? polarity : ~polarity
  task automatic drive(input logic r, input logic w, input logic o, input logic e);
    rd_s  = ~(r ^ pol[0]);
    wr_s  = ~(w ^ pol[1]);
    oe_s  = ~(o ^ pol[2]);
    end_s = ~(e ^ pol[3]);
  endtask

  task automatic idle();
    m_lo = 1'b0; m_hi = 1'b0;
    drive(0, 0, 0, 0);
    @(negedge clk);
  endtask

  task automatic push(input logic [15:0] w);
    m_drv = w; m_lo = 1'b1; m_hi = 1'b1;
    drive(0, 1, 0, 0);
    @(negedge clk);
    m_lo = 1'b0; m_hi = 1'b0;
    drive(0, 0, 0, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    m_lo = 1'b0; m_hi = 1'b0;
    drive(0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // show current word with output enable, then pop it at the next edge
  task automatic pop_check(input string tag, input logic [15:0] exp);
    m_lo = 1'b0; m_hi = 1'b0;
    drive(0, 0, 1, 0);
    #1;
    check(tag, fd, exp);
    drive(1, 0, 1, 0);
    @(negedge clk);
    drive(0, 0, 0, 0);
  endtask

  function automatic logic [15:0] val(input int p, input int a, input int k);
    return 16'((p << 12) | (a << 8) | (k * 17 + 3));
  endfunction

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // polarity x address sweep
    for (int p = 0; p < 16; p++) begin
      pol = 4'(p);
      do_reset();
      check("R1 empty flag after reset", 16'(fempty), 16'd1);
      check("R1 full flag after reset", 16'(ffull), 16'd0);
      m_drv = 16'h5AA5; m_lo = 1'b1; m_hi = 1'b1; #1;
      check("R1 R4 bus released", fd, 16'h5AA5);
      m_lo = 1'b0; m_hi = 1'b0;
      wide = 1'b1; plen = 8'd4;
      for (int a = 0; a < 4; a++) begin
        addr = 2'(a);
        push(val(p, a, 0));
        push(val(p, a, 1));
      end
      for (int a = 0; a < 4; a++) begin
        addr = 2'(a);
        idle();
        check("R6 R10 committed packet visible", 16'(fempty), 16'd0);
        drive(0, 0, 1, 0); #1;
        check("R3 R2 first word on bus", fd, val(p, a, 0));
        @(negedge clk);
        check("R5 output enable holds pointer", fd, val(p, a, 0));
        drive(1, 0, 1, 0);
        @(negedge clk);
        check("R5 read advances pointer", fd, val(p, a, 1));
        @(negedge clk);
        idle();
        check("R2 FIFO drained", 16'(fempty), 16'd1);
      end
    end

    pol = 4'b0101;
    // R6 R9 R10: uncommitted data hidden, flag latency
    do_reset();
    wide = 1'b1; plen = 8'd6; addr = 2'd1;
    push(16'hA001);
    push(16'hA002);
    idle();
    check("R6 open packet hidden", 16'(fempty), 16'd1);
    drive(1, 0, 1, 0);
    @(negedge clk);
    drive(0, 0, 0, 0);
    push(16'hA003);
    check("R10 flag still old right after commit edge", 16'(fempty), 16'd1);
    idle();
    check("R10 flag updates one edge later", 16'(fempty), 16'd0);
    pop_check("R9 read of empty FIFO ignored", 16'hA001);
    pop_check("R6 second word", 16'hA002);
    pop_check("R6 third word", 16'hA003);
    idle();
    check("R6 drained", 16'(fempty), 16'd1);

    // R7 packet end
    addr = 2'd2;
    idle();
    push(16'hB001);
    m_drv = 16'hB002; m_lo = 1'b1; m_hi = 1'b1;
    drive(0, 1, 0, 1);
    @(negedge clk);
    idle();
    check("R7 packet end with write ignored", 16'(fempty), 16'd1);
    drive(0, 0, 0, 1);
    @(negedge clk);
    idle();
    check("R7 packet end commits short packet", 16'(fempty), 16'd0);
    pop_check("R7 short word 0", 16'hB001);
    pop_check("R7 short word 1", 16'hB002);
    idle();
    check("R7 short packet drained", 16'(fempty), 16'd1);
    drive(0, 0, 0, 1);
    @(negedge clk);
    idle();
    check("R7 packet end with nothing open ignored", 16'(fempty), 16'd1);

    // R8 full by packet count
    addr = 2'd3; plen = 8'd2;
    idle();
    for (int k = 0; k < 4; k++) push(16'hC000 + 16'(k));
    idle();
    check("R8 full at packet limit", 16'(ffull), 16'd1);
    push(16'hCFFF);
    for (int k = 0; k < 4; k++) pop_check("R8 packet data", 16'hC000 + 16'(k));
    idle();
    check("R8 write while full dropped", 16'(fempty), 16'd1);
    check("R8 full cleared", 16'(ffull), 16'd0);

    // R8 full by word count
    addr = 2'd0; plen = 8'd32;
    idle();
    for (int k = 0; k < 8; k++) push(16'hD000 + 16'(k));
    idle();
    check("R8 full at depth", 16'(ffull), 16'd1);
    check("R8 R6 nothing committed yet", 16'(fempty), 16'd1);
    push(16'hDFFF);
    drive(0, 0, 0, 1);
    @(negedge clk);
    idle();
    check("R7 long packet committed", 16'(fempty), 16'd0);
    for (int k = 0; k < 8; k++) pop_check("R8 depth data", 16'hD000 + 16'(k));
    idle();
    check("R8 extra word absent", 16'(fempty), 16'd1);

    // R11 R4 narrow bus
    do_reset();
    wide = 1'b0; plen = 8'd2; addr = 2'd1;
    push(16'hAB31);
    push(16'hAB42);
    idle();
    check("R11 narrow packet of two bytes", 16'(fempty), 16'd0);
    m_drv = 16'h7E00; m_hi = 1'b1; m_lo = 1'b0;
    drive(0, 0, 1, 0); #1;
    check("R4 R11 narrow drives low byte only", fd, 16'h7E31);
    drive(1, 0, 1, 0);
    @(negedge clk);
    #1;
    check("R11 narrow second byte", fd, 16'h7E42);
    idle();
    idle();
    check("R11 narrow drained", 16'(fempty), 16'd0);
    drive(1, 0, 0, 0);
    @(negedge clk);
    idle();
    check("R11 narrow empty", 16'(fempty), 16'd1);

    finish_run();
  end

endmodule